// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits behind a two-wire bus slave and turns its byte writes into safe updates of a 256-byte register array. Data bytes that follow a word address are held in a page buffer of eight slots. They reach the array only when the bus transfer closes with a STOP. A new START discards whatever is still held, and so does a STOP while the write-protect level is high. After a commit has been accepted, the block reports busy for a fixed write window and refuses all new traffic until that window closes.

Two locations of the array also act as control registers for a pair of wiper positions. Location F9h drives a 100-step channel, and any stored value above 99 selects the top step. Location F8h drives a 256-step channel directly. The six locations above F9h are reserved and are never written. The wiper codes change only at the end of a busy window. After a reset they are reloaded from the array, which keeps its contents through the reset.

Top module: `page_commit_ctrl`

## Requirements
- R1: The first data byte of a transfer goes to the word address given with it. Each later byte goes to the next slot of the same aligned 8-byte page, and the slot index wraps from 7 to 0. A ninth or later byte overwrites the slot that an earlier byte of the same transfer filled.
- R2: Held bytes appear on the memory write port only after `stop_stb`. A `start_stb` that arrives before the STOP discards them.
- R3: A commit raises `busy` in the cycle after `stop_stb`. `busy` then stays high for exactly PAGE_BYTES + WRITE_CYCLES cycles. Each held byte is written exactly once, in increasing slot order, while `busy` is high.
- R4: While `busy` is high, `start_stb`, `wr_stb` and `stop_stb` are ignored.
- R5: If `wp` is 1 when `stop_stb` arrives, the held bytes are discarded, nothing is written and `busy` stays low.
- R6: Addresses FAh to FFh are never driven on the write port.
- R7: `wiper_a` equals the byte stored at F9h, saturated to 99 (63h). `wiper_b` equals the byte stored at F8h.
- R8: The wiper outputs change only on the clock edge where `busy` falls.
- R9: After reset, `busy` is high while F8h and F9h are read back. The wipers then show the stored values. The array keeps its contents across a reset, and its initial contents are all zero.
- R10: A `stop_stb` with no held bytes has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_stb | input | 1 | START seen on the bus; discards held bytes |
| wr_stb | input | 1 | One received data byte |
| wr_addr | input | 8 | Word address of the transfer |
| wr_data | input | 8 | Received data byte |
| stop_stb | input | 1 | STOP seen on the bus |
| wp | input | 1 | Write protect level, 1 blocks commits |
| busy | output | 1 | Commit or reload in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | 8 | Array write address |
| mem_wdata | output | 8 | Array write data |
| wiper_a | output | 7 | 100-step wiper code |
| wiper_b | output | 8 | 256-step wiper code |

## Verification
The hardest situation to reach is traffic that arrives while the block is busy. The bench has to show that a full START, write and STOP sequence inside the busy window leaves no trace. To do this it launches a commit, replays a complete transfer during the window, and then issues a bare STOP after the window closes. Any byte that had been accepted would then surface on the write port. A second hard case is the reload after reset: the bench first commits wiper values, then pulses reset and compares the reloaded codes with its own model of the array.

// File: rtl/pcc_pkg.sv
package pcc_pkg;
  typedef enum logic [2:0] {
    ST_INIT_A,
    ST_INIT_B,
    ST_INIT_C,
    ST_IDLE,
    ST_COMMIT,
    ST_HOLD
  } pcc_state_t;
endpackage

// File: rtl/pcc_gather.sv
module pcc_gather #(
  parameter int ADDR_W     = 8,
  parameter int DATA_W     = 8,
  parameter int PAGE_BYTES = 8,
  parameter int OFS_W      = 3
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               clr,
  input  logic                               wr_en,
  input  logic [ADDR_W-1:0]                  wr_addr,
  input  logic [DATA_W-1:0]                  wr_data,
  output logic [ADDR_W-OFS_W-1:0]            page,
  output logic [PAGE_BYTES-1:0]              slot_valid,
  output logic [PAGE_BYTES-1:0][DATA_W-1:0]  slot_data
);
  logic             active;
  logic [OFS_W-1:0] next_ofs;
  logic [OFS_W-1:0] slot;

  // first byte takes its slot from the address, later bytes follow on
  assign slot = active ? next_ofs : wr_addr[OFS_W-1:0];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      active     <= 1'b0;
      next_ofs   <= '0;
      slot_valid <= '0;
      page       <= '0;
    end else if (wr_en) begin
      if (!active) page <= wr_addr[ADDR_W-1:OFS_W];
      active           <= 1'b1;
      slot_valid[slot] <= 1'b1;
      next_ofs         <= slot + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en && !clr) slot_data[slot] <= wr_data;
  end
endmodule

// File: rtl/pcc_store.sv
module pcc_store #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = '0;
  end

  always @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/pcc_clamp.sv
module pcc_clamp #(
  parameter int IN_W  = 8,
  parameter int OUT_W = 7,
  parameter int MAX   = 99
) (
  input  logic [IN_W-1:0]  raw,
  output logic [OUT_W-1:0] code
);
  generate
    if (MAX >= (1 << IN_W) - 1) begin : g_pass
      assign code = OUT_W'(raw);
    end else begin : g_sat
      assign code = (raw > IN_W'(MAX)) ? OUT_W'(MAX) : OUT_W'(raw);
    end
  endgenerate
endmodule

// File: rtl/page_commit_ctrl.sv
module page_commit_ctrl
  import pcc_pkg::*;
#(
  parameter int              ADDR_W       = 8,
  parameter int              DATA_W       = 8,
  parameter int              PAGE_BYTES   = 8,
  parameter int              WRITE_CYCLES = 500000,
  parameter logic [ADDR_W-1:0] WIPER_A_ADDR = 'hF9,
  parameter logic [ADDR_W-1:0] WIPER_B_ADDR = 'hF8,
  parameter logic [ADDR_W-1:0] RESV_LO      = 'hFA,
  parameter int              WIPER_A_MAX  = 99,
  parameter int              WIPER_A_W    = 7
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_stb,
  input  logic                 wr_stb,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic                 stop_stb,
  input  logic                 wp,
  output logic                 busy,
  output logic                 mem_we,
  output logic [ADDR_W-1:0]    mem_addr,
  output logic [DATA_W-1:0]    mem_wdata,
  output logic [WIPER_A_W-1:0] wiper_a,
  output logic [DATA_W-1:0]    wiper_b
);
  localparam int OFS_W  = $clog2(PAGE_BYTES);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam int CNT_W  = $clog2(WRITE_CYCLES + 1);

  pcc_state_t                       state;
  logic [OFS_W-1:0]                 slot_idx;
  logic [CNT_W-1:0]                 hold_cnt;
  logic [DATA_W-1:0]                shadow_a, shadow_b;
  logic [WIPER_A_W-1:0]             a_code;
  logic [DATA_W-1:0]                b_code;
  logic [DATA_W-1:0]                rd_data;
  logic [ADDR_W-1:0]                rd_addr;
  logic [PAGE_W-1:0]                g_page;
  logic [PAGE_BYTES-1:0]            g_valid;
  logic [PAGE_BYTES-1:0][DATA_W-1:0] g_data;

  logic idle, any_valid, last_slot, g_clr, g_wr, c_valid;
  logic [ADDR_W-1:0] c_addr;
  logic [DATA_W-1:0] c_data;

  assign idle      = (state == ST_IDLE);
  assign any_valid = |g_valid;
  assign last_slot = (slot_idx == OFS_W'(PAGE_BYTES - 1));
  assign c_addr    = {g_page, slot_idx};
  assign c_valid   = g_valid[slot_idx];
  assign c_data    = g_data[slot_idx];
  assign g_wr      = idle & wr_stb;
  assign g_clr     = (idle & start_stb)
                   | (idle & stop_stb & (wp | ~any_valid))
                   | ((state == ST_COMMIT) & last_slot);
  assign rd_addr   = (state == ST_INIT_A) ? WIPER_B_ADDR : WIPER_A_ADDR;

  pcc_gather #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES), .OFS_W(OFS_W)
  ) u_gather (
    .clk(clk), .rst(rst), .clr(g_clr), .wr_en(g_wr),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .page(g_page), .slot_valid(g_valid), .slot_data(g_data)
  );

  pcc_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk(clk), .we(mem_we), .waddr(mem_addr), .wdata(mem_wdata),
    .raddr(rd_addr), .rdata(rd_data)
  );

  pcc_clamp #(.IN_W(DATA_W), .OUT_W(WIPER_A_W), .MAX(WIPER_A_MAX)) u_clamp_a (
    .raw(shadow_a), .code(a_code)
  );

  pcc_clamp #(.IN_W(DATA_W), .OUT_W(DATA_W), .MAX((1 << DATA_W) - 1)) u_clamp_b (
    .raw(shadow_b), .code(b_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_INIT_A;
      busy      <= 1'b1;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      slot_idx  <= '0;
      hold_cnt  <= '0;
      shadow_a  <= '0;
      shadow_b  <= '0;
      wiper_a   <= '0;
      wiper_b   <= '0;
    end else begin
      mem_we <= 1'b0;
      unique case (state)
        ST_INIT_A: state <= ST_INIT_B;
        ST_INIT_B: begin
          shadow_b <= rd_data;
          state    <= ST_INIT_C;
        end
        ST_INIT_C: begin
          shadow_a <= rd_data;
          hold_cnt <= '0;
          state    <= ST_HOLD;
        end
        ST_IDLE: begin
          if (stop_stb && !wp && any_valid) begin
            state    <= ST_COMMIT;
            busy     <= 1'b1;
            slot_idx <= '0;
          end
        end
        ST_COMMIT: begin
          if (c_valid && (c_addr < RESV_LO)) begin
            mem_we    <= 1'b1;
            mem_addr  <= c_addr;
            mem_wdata <= c_data;
            if (c_addr == WIPER_A_ADDR) shadow_a <= c_data;
            if (c_addr == WIPER_B_ADDR) shadow_b <= c_data;
          end
          slot_idx <= slot_idx + 1'b1;
          if (last_slot) begin
            state    <= ST_HOLD;
            hold_cnt <= CNT_W'(WRITE_CYCLES - 1);
          end
        end
        ST_HOLD: begin
          if (hold_cnt == '0) begin
            state   <= ST_IDLE;
            busy    <= 1'b0;
            wiper_a <= a_code;
            wiper_b <= b_code;
          end else begin
            hold_cnt <= hold_cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pcc_checker.sv
module pcc_checker #(
  parameter int              ADDR_W      = 8,
  parameter int              DATA_W      = 8,
  parameter int              WIPER_A_W   = 7,
  parameter int              WIPER_A_MAX = 99,
  parameter logic [ADDR_W-1:0] RESV_LO     = 'hFA
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 stop_stb,
  input logic                 wp,
  input logic                 busy,
  input logic                 mem_we,
  input logic [ADDR_W-1:0]    mem_addr,
  input logic [WIPER_A_W-1:0] wiper_a,
  input logic [DATA_W-1:0]    wiper_b
);
  assert_write_in_window_R3: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);

  assert_busy_after_stop_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(stop_stb) && !$past(wp)));

  assert_no_reserved_write_R6: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr < RESV_LO));

  assert_wiper_a_saturated_R7: assert property (@(posedge clk) disable iff (rst)
    wiper_a <= WIPER_A_W'(WIPER_A_MAX));

  assert_wipers_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> ($stable(wiper_a) && $stable(wiper_b)));
endmodule

bind page_commit_ctrl pcc_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WIPER_A_W(WIPER_A_W),
  .WIPER_A_MAX(WIPER_A_MAX), .RESV_LO(RESV_LO)
) u_chk (.*);

// File: tb/page_commit_ctrl_test.sv
`timescale 1ns/1ps
module page_commit_ctrl_test;
  localparam int WT = 20;
  localparam int PB = 8;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       start_stb = 1'b0, wr_stb = 1'b0, stop_stb = 1'b0, wp = 1'b1;
  logic [7:0] wr_addr = '0, wr_data = '0;
  logic       busy, mem_we;
  logic [7:0] mem_addr, mem_wdata, wiper_b;
  logic [6:0] wiper_a;

  page_commit_ctrl #(.WRITE_CYCLES(WT)) uut (
    .clk(clk), .rst(rst), .start_stb(start_stb), .wr_stb(wr_stb),
    .wr_addr(wr_addr), .wr_data(wr_data), .stop_stb(stop_stb), .wp(wp),
    .busy(busy), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .wiper_a(wiper_a), .wiper_b(wiper_b)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0, nwrites = 0, resv_hits = 0;
  logic [7:0] expm [256];
  logic [7:0] obs  [256];
  logic [7:0] pd [PB];
  bit         pv [PB];
  logic [4:0] ppage;
  logic [2:0] pofs;
  bit         pact;

  always @(negedge clk) begin
    if (!rst && mem_we) begin
      obs[mem_addr] = mem_wdata;
      nwrites++;
      if (mem_addr >= 8'hFA) resv_hits++;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R3 watchdog: cycles %0d expected below 150000", cyc);
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int exp_wa();
    return (expm[8'hF9] > 8'd99) ? 99 : int'(expm[8'hF9]);
  endfunction

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic clear_model();
    for (int i = 0; i < PB; i++) pv[i] = 0;
    pact = 0;
    pofs = '0;
  endtask

  task automatic send_start();
    start_stb = 1'b1; tick(); start_stb = 1'b0;
    clear_model();
  endtask

  task automatic send_byte(input logic [7:0] a, input logic [7:0] d);
    wr_stb = 1'b1; wr_addr = a; wr_data = d; tick(); wr_stb = 1'b0;
    if (!pact) begin ppage = a[7:3]; pofs = a[2:0]; pact = 1; end
    pv[pofs] = 1; pd[pofs] = d; pofs = pofs + 3'd1;
  endtask

  task automatic send_stop(input string req);
    bit any = 0;
    int c = 0;
    int old_a = exp_wa();
    int old_b = int'(expm[8'hF8]);
    for (int i = 0; i < PB; i++) any |= pv[i];
    stop_stb = 1'b1; tick(); stop_stb = 1'b0;
    while (busy && c < 2000) begin
      c++;
      if (c == 2) begin
        check(int'(wiper_a) == old_a, "R8 wiper_a held during busy", int'(wiper_a), old_a);
        check(int'(wiper_b) == old_b, "R8 wiper_b held during busy", int'(wiper_b), old_b);
      end
      tick();
    end
    if (!wp && any) begin
      for (int i = 0; i < PB; i++) begin
        logic [7:0] a = {ppage, 3'(i)};
        if (pv[i] && a < 8'hFA) expm[a] = pd[i];
      end
      check(c == PB + WT, {req, " R3 busy length"}, c, PB + WT);
    end else begin
      check(c == 0, {req, " busy stays low"}, c, 0);
    end
    clear_model();
  endtask

  task automatic compare_all(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (obs[i] !== expm[i]) bad++;
    check(bad == 0, {req, " array contents"}, bad, 0);
    check(int'(wiper_a) == exp_wa(), {req, " R7 wiper_a"}, int'(wiper_a), exp_wa());
    check(int'(wiper_b) == int'(expm[8'hF8]), {req, " R7 wiper_b"}, int'(wiper_b), int'(expm[8'hF8]));
  endtask

  task automatic do_reset();
    int c = 0;
    rst = 1'b1; repeat (3) tick(); rst = 1'b0;
    tick();
    check(busy == 1'b1, "R9 busy during reload", int'(busy), 1);
    while (busy && c < 100) begin c++; tick(); end
  endtask

  initial begin
    int n0;
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) begin expm[i] = '0; obs[i] = '0; end
    clear_model();
    wp = 1'b0;
    do_reset();
    compare_all("R9 reset state");

    // R2 / R3: single byte commit
    send_start(); send_byte(8'h10, 8'hA5); send_stop("R2");
    compare_all("R2 single byte");

    // R1: ten bytes from offset 6 wrap inside the page
    send_start();
    for (int i = 0; i < 10; i++) send_byte(8'h16, 8'h30 + 8'(i));
    send_stop("R1");
    compare_all("R1 page wrap");

    // R2: transfer ended by START is dropped
    n0 = nwrites;
    send_start(); send_byte(8'h40, 8'h11); send_byte(8'h40, 8'h12);
    send_start(); send_stop("R2 discard");
    check(nwrites == n0, "R2 no write after restart", nwrites, n0);
    send_start(); send_byte(8'h48, 8'h77); send_stop("R2");
    compare_all("R2 second transfer");

    // R5 / R10: protected stop discards, later empty stop does nothing
    n0 = nwrites;
    wp = 1'b1;
    send_start(); send_byte(8'h50, 8'hEE); send_stop("R5");
    wp = 1'b0;
    send_stop("R10");
    check(nwrites == n0, "R5 no write while protected", nwrites, n0);
    compare_all("R5 R10");

    // R4: traffic inside the busy window is ignored
    send_start(); send_byte(8'h60, 8'h21);
    stop_stb = 1'b1; tick(); stop_stb = 1'b0;
    tick();
    start_stb = 1'b1; tick(); start_stb = 1'b0;
    wr_stb = 1'b1; wr_addr = 8'h61; wr_data = 8'h99; tick(); wr_stb = 1'b0;
    stop_stb = 1'b1; tick(); stop_stb = 1'b0;
    while (busy) tick();
    for (int i = 0; i < PB; i++) if (pv[i]) expm[{ppage, 3'(i)}] = pd[i];
    clear_model();
    n0 = nwrites;
    send_stop("R4 late stop");
    check(nwrites == n0, "R4 bytes sent while busy dropped", nwrites, n0);
    compare_all("R4");

    // R6 / R7: wiper page, reserved tail dropped, saturation
    send_start();
    send_byte(8'hF8, 8'h3C);
    send_byte(8'hF8, 8'h80);
    for (int i = 0; i < 6; i++) send_byte(8'hF8, 8'hC0 + 8'(i));
    send_stop("R6");
    check(resv_hits == 0, "R6 reserved writes", resv_hits, 0);
    compare_all("R6 R7 wiper page");
    send_start(); send_byte(8'hF9, 8'h63); send_stop("R7");
    compare_all("R7 top code");
    send_start(); send_byte(8'hF9, 8'h64); send_stop("R7");
    compare_all("R7 first saturated code");
    send_start(); send_byte(8'hF9, 8'h42); send_byte(8'hF9, 8'hFF); send_stop("R7");
    compare_all("R7 direct code");

    // R9: reload after reset
    do_reset();
    compare_all("R9 reload");

    // random traffic
    for (int t = 0; t < 40; t++) begin
      logic [7:0] a = 8'($urandom_range(0, 255));
      int n = $urandom_range(1, 10);
      send_start();
      for (int i = 0; i < n; i++) send_byte(a, 8'($urandom));
      wp = ($urandom_range(0, 4) == 0);
      if ($urandom_range(0, 5) == 0) send_start();
      send_stop("R3 random");
      wp = 1'b0;
      compare_all("R1 R2 random");
    end
    check(resv_hits == 0, "R6 reserved writes total", resv_hits, 0);

    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end
endmodule